// File: doc/BRIEF.md
# Steered-Beam Energy Scanner

This block forms delay-and-sum beams from a synchronous set of microphone PCM samples. Every accepted input beat carries one sample per channel. The sample goes into a small circular delay store for each channel. The block then steps through every steering angle, one angle per clock. For each angle it reads a constant table of per-channel delays, fetches the delayed samples, adds them to form that angle's beam value, and squares the beam value into an energy accumulator for that angle. A new sample cannot be accepted until all angles of the current sample have been processed.

When an averaging window closes, the block stores a mean-square level for every angle. It also records the angle with the highest level, called the dominant direction. Software or a display reads the stored levels through a plain angle-select port. While this runs, a live output stream delivers one beat per processed sample. Each beat holds the beam value of one chosen direction and the raw sample of one chosen microphone.

Both data interfaces use valid/ready. An input beat is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while a sweep runs. It is also low while a live beat is waiting to be taken, so a stall on the output stream pushes back onto the input. A live beat stays valid with unchanged data until `live_ready` takes it.

Top module: `beam_scan_top`

## Requirements
- R1: `in_ready` is low on the cycle after an input beat is accepted. It stays low until all angles have been processed for that beat and no live beat is pending. While `live_valid` is high and `live_ready` is low, `live_valid`, `live_beam` and `live_mic` hold their values.
- R2: Channel c of `in_data` occupies bits [c*SAMPLE_W +: SAMPLE_W], as signed two's complement. The delay for angle a and channel c is the field of DLY_TABLE at bits [(a*NUM_CH+c)*DLY_W +: DLY_W], where DLY_W = log2(DLY_DEPTH). The beam value for angle a is the sum, over all channels, of the sample of channel c taken that many input beats earlier. A delay of 0 uses the current beat.
- R3: Each processed beat produces exactly one live beat. `live_beam` is the beam value of angle `dir_sel`. `live_mic` is the current sample of channel `mic_sel`. Both selects are sampled when the input beat is accepted.
- R4: The first DLY_DEPTH-1 beats after reset only fill the delay store. They produce no live beat and add nothing to any energy window.
- R5: Window length is WIN_SHORT processed beats when `win_long`=0 and WIN_LONG when `win_long`=1. `win_long` is sampled on the first beat of each window. A change in the middle of a window has no effect until the next window starts.
- R6: With `pol_sel`=a, `pol_energy` is floor(sum of beam(a)^2 over the last completed window / window length).
- R7: `dom_angle` is the angle with the largest level in the last completed window. When several angles tie, the lowest index wins.
- R8: `pol_valid` is low from reset until the first window completes, then stays high. Levels and `dom_angle` change only when a window completes.
- R9: During and after reset, `in_ready`=1, `live_valid`=0 and `pol_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | NUM_CH*SAMPLE_W | One signed sample per channel |
| win_long | input | 1 | Selects the long averaging window |
| dir_sel | input | ANG_W | Angle whose beam goes to the live stream |
| mic_sel | input | CH_W | Channel whose sample goes to the live stream |
| live_valid | output | 1 | Live beat valid |
| live_ready | input | 1 | Live beat taken |
| live_beam | output | SUM_W | Signed beam value for the selected angle |
| live_mic | output | SAMPLE_W | Sample of the selected channel |
| pol_sel | input | ANG_W | Angle whose level is shown on `pol_energy` |
| pol_energy | output | ACC_W | Mean-square level of the selected angle |
| pol_valid | output | 1 | At least one window has completed |
| dom_angle | output | ANG_W | Index of the loudest angle |

## Verification
Two situations are hard to reach from the ports. The first is a window-length change made in the middle of a window. The bench flips `win_long` a few beats into a long window and checks that the levels reported at its end are still divided by the long length. The second is an exact tie for the maximum level. The bench feeds a constant signal on every channel long enough for the whole delay history to be uniform, so every angle ends with identical energy and index 0 must be reported. A stalled live stream is produced by holding `live_ready` low during an active beat, and the bench watches that the input side closes.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  localparam int TBL_MAX = 4096;

  typedef enum logic {ST_IDLE, ST_SWEEP} scan_state_t;

  // Default steering table: delay grows with angle and channel index, wrapped into the store depth.
  function automatic logic [TBL_MAX-1:0] build_table(int n_ang, int n_ch, int dw, int depth);
    logic [TBL_MAX-1:0] t;
    t = '0;
    for (int a = 0; a < n_ang; a++) begin
      for (int c = 0; c < n_ch; c++) begin
        int v;
        v = (a * (c + 1)) % depth;
        for (int b = 0; b < dw; b++) t[(a*n_ch+c)*dw + b] = v[b];
      end
    end
    return t;
  endfunction

endpackage

// File: rtl/bsc_delay_ram.sv
module bsc_delay_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // One write port for the incoming beat, one registered read port for the sweep.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/bsc_energy_win.sv
module bsc_energy_win #(
  parameter int NUM_ANG   = 60,
  parameter int ANG_W     = 6,
  parameter int SUM_W     = 18,
  parameter int SQ_W      = 36,
  parameter int ACC_W     = 52,
  parameter int WIN_SHORT = 6000,
  parameter int WIN_LONG  = 48000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    s_valid,
  input  logic                    s_last,
  input  logic [ANG_W-1:0]        s_ang,
  input  logic signed [SUM_W-1:0] s_beam,
  input  logic                    win_long,
  input  logic [ANG_W-1:0]        pol_sel,
  output logic [ACC_W-1:0]        pol_energy,
  output logic                    pol_valid,
  output logic [ANG_W-1:0]        dom_angle
);
  localparam int CNT_W = $clog2(WIN_LONG);

  logic [ACC_W-1:0] acc [NUM_ANG];
  logic [ACC_W-1:0] res [NUM_ANG];
  logic [CNT_W-1:0] win_cnt;
  logic             cur_long, res_long;
  logic [ACC_W-1:0] best;
  logic [ANG_W-1:0] best_i;

  logic signed [SQ_W-1:0] bx;
  logic [SQ_W-1:0]        sq;
  logic [ACC_W-1:0]       acc_cur, total;
  logic                   eff_long, wnd_end, better, step;

  always_comb begin
    bx       = SQ_W'(s_beam);
    sq       = bx * bx;
    acc_cur  = acc[s_ang];
    total    = acc_cur + ACC_W'(sq);
    eff_long = (win_cnt == '0) ? win_long : cur_long;
    wnd_end  = eff_long ? (win_cnt == CNT_W'(WIN_LONG - 1)) : (win_cnt == CNT_W'(WIN_SHORT - 1));
    // Strict compare during an ascending sweep keeps the lowest index on ties.
    better   = (s_ang == '0) || (total > best);
    step     = s_valid && en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_ANG; a++) begin
        acc[a] <= '0;
        res[a] <= '0;
      end
      win_cnt   <= '0;
      cur_long  <= 1'b0;
      res_long  <= 1'b0;
      best      <= '0;
      best_i    <= '0;
      dom_angle <= '0;
      pol_valid <= 1'b0;
    end else if (step) begin
      if (wnd_end) begin
        res[s_ang] <= total;
        acc[s_ang] <= '0;
        if (better) begin
          best   <= total;
          best_i <= s_ang;
        end
        if (s_last) begin
          dom_angle <= better ? s_ang : best_i;
          pol_valid <= 1'b1;
          res_long  <= eff_long;
        end
      end else begin
        acc[s_ang] <= total;
      end
      if (s_last) begin
        win_cnt <= wnd_end ? '0 : win_cnt + 1'b1;
        if (win_cnt == '0) cur_long <= win_long;
      end
    end
  end

  always_comb begin
    pol_energy = res[pol_sel] / (res_long ? ACC_W'(WIN_LONG) : ACC_W'(WIN_SHORT));
  end

  a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pol_valid |=> pol_valid);
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (total >= acc_cur));
  a_r7_dom_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && s_last && wnd_end) |=> $stable(dom_angle));
endmodule

// File: rtl/beam_scan_top.sv
module beam_scan_top #(
  parameter int NUM_CH     = 4,
  parameter int SAMPLE_W   = 16,
  parameter int NUM_ANG    = 60,
  parameter int DLY_DEPTH  = 16,
  parameter int WIN_SHORT  = 6000,
  parameter int WIN_LONG   = 48000,
  parameter logic [bsc_pkg::TBL_MAX-1:0] DLY_TABLE =
    bsc_pkg::build_table(NUM_ANG, NUM_CH, $clog2(DLY_DEPTH), DLY_DEPTH),
  localparam int DLY_W = $clog2(DLY_DEPTH),
  localparam int ANG_W = $clog2(NUM_ANG),
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int SUM_W = SAMPLE_W + $clog2(NUM_CH),
  localparam int SQ_W  = 2 * SUM_W,
  localparam int ACC_W = SQ_W + $clog2(WIN_LONG + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [NUM_CH*SAMPLE_W-1:0] in_data,
  input  logic                       win_long,
  input  logic [ANG_W-1:0]           dir_sel,
  input  logic [CH_W-1:0]            mic_sel,
  output logic                       live_valid,
  input  logic                       live_ready,
  output logic signed [SUM_W-1:0]    live_beam,
  output logic [SAMPLE_W-1:0]        live_mic,
  input  logic [ANG_W-1:0]           pol_sel,
  output logic [ACC_W-1:0]           pol_energy,
  output logic                       pol_valid,
  output logic [ANG_W-1:0]           dom_angle
);
  import bsc_pkg::*;

  scan_state_t       state;
  logic [DLY_W-1:0]  wptr;
  logic [DLY_W:0]    fill_cnt;
  logic              act, issuing;
  logic [ANG_W-1:0]  ang0, dir_q;
  logic              s_valid, s_last;
  logic [ANG_W-1:0]  s_ang;
  logic [SAMPLE_W-1:0] mic_hold;
  logic signed [SUM_W-1:0] beam, beam_hold;
  logic              accept;

  logic [DLY_W-1:0]    raddr [NUM_CH];
  logic [SAMPLE_W-1:0] rd    [NUM_CH];

  assign in_ready = (state == ST_IDLE) && !live_valid;
  assign accept   = in_valid && in_ready;

  // Read address per channel: newest write slot minus the steering delay, wrapping in the store.
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      raddr[c] = wptr - DLY_TABLE[(int'(ang0)*NUM_CH + c)*DLY_W +: DLY_W];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bsc_delay_ram #(.W(SAMPLE_W), .DEPTH(DLY_DEPTH)) u_ram (
      .clk   (clk),
      .we    (accept),
      .waddr (wptr),
      .wdata (in_data[c*SAMPLE_W +: SAMPLE_W]),
      .raddr (raddr[c]),
      .rdata (rd[c])
    );
  end

  always_comb begin
    beam = '0;
    for (int c = 0; c < NUM_CH; c++) beam = beam + SUM_W'($signed(rd[c]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      wptr       <= '0;
      fill_cnt   <= '0;
      act        <= 1'b0;
      issuing    <= 1'b0;
      ang0       <= '0;
      dir_q      <= '0;
      s_valid    <= 1'b0;
      s_last     <= 1'b0;
      s_ang      <= '0;
      mic_hold   <= '0;
      beam_hold  <= '0;
      live_valid <= 1'b0;
      live_beam  <= '0;
      live_mic   <= '0;
    end else begin
      if (live_valid && live_ready) live_valid <= 1'b0;
      if (accept) begin
        state    <= ST_SWEEP;
        issuing  <= 1'b1;
        ang0     <= '0;
        dir_q    <= dir_sel;
        mic_hold <= in_data[int'(mic_sel)*SAMPLE_W +: SAMPLE_W];
        act      <= (fill_cnt >= (DLY_W+1)'(DLY_DEPTH - 1));
        if (fill_cnt != (DLY_W+1)'(DLY_DEPTH)) fill_cnt <= fill_cnt + 1'b1;
      end
      // Stage 0: issue one angle's reads per cycle.
      if (issuing) begin
        s_valid <= 1'b1;
        s_ang   <= ang0;
        s_last  <= (ang0 == ANG_W'(NUM_ANG - 1));
        if (ang0 == ANG_W'(NUM_ANG - 1)) issuing <= 1'b0;
        else ang0 <= ang0 + 1'b1;
      end else begin
        s_valid <= 1'b0;
        s_last  <= 1'b0;
      end
      // Stage 1: beam value available; capture the steered direction, close the sweep.
      if (s_valid) begin
        if (s_ang == dir_q) beam_hold <= beam;
        if (s_last) begin
          state <= ST_IDLE;
          wptr  <= wptr + 1'b1;
          if (act) begin
            live_valid <= 1'b1;
            live_beam  <= (s_ang == dir_q) ? beam : beam_hold;
            live_mic   <= mic_hold;
          end
        end
      end
    end
  end

  bsc_energy_win #(
    .NUM_ANG(NUM_ANG), .ANG_W(ANG_W), .SUM_W(SUM_W), .SQ_W(SQ_W), .ACC_W(ACC_W),
    .WIN_SHORT(WIN_SHORT), .WIN_LONG(WIN_LONG)
  ) u_energy (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (act),
    .s_valid    (s_valid),
    .s_last     (s_last),
    .s_ang      (s_ang),
    .s_beam     (beam),
    .win_long   (win_long),
    .pol_sel    (pol_sel),
    .pol_energy (pol_energy),
    .pol_valid  (pol_valid),
    .dom_angle  (dom_angle)
  );

  a_r1_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (live_valid && !live_ready) |=> (live_valid && $stable(live_beam) && $stable(live_mic)));
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  a_r4_live_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live_valid) |-> (fill_cnt == (DLY_W+1)'(DLY_DEPTH)));
endmodule

// File: tb/tb_beam_scan_top.sv
module tb_beam_scan_top;
  localparam int NCH = 3, SW = 16, NANG = 6, DEPTH = 8, WS = 4, WL = 8;
  localparam int ANGW = 3, CHW = 2, SUMW = 18, ACCW = 40;

  localparam int DLY [NANG][NCH] = '{
    '{0, 0, 0}, '{1, 0, 2}, '{3, 5, 7}, '{2, 4, 6}, '{0, 1, 2}, '{7, 7, 0}};

  function automatic logic [4095:0] pack_tbl();
    logic [4095:0] t;
    t = '0;
    for (int a = 0; a < NANG; a++)
      for (int c = 0; c < NCH; c++)
        t[(a*NCH+c)*3 +: 3] = 3'(DLY[a][c]);
    return t;
  endfunction

  // Stimulus table: three channel samples, steered angle, chosen microphone.
  localparam int VEC [16][5] = '{
    '{ 300, -200,  100, 0, 0}, '{-450,  120,  800, 1, 1}, '{  50,  700, -900, 2, 2},
    '{1000,    0, -300, 3, 0}, '{ -20, -600,  400, 4, 1}, '{ 250,  250,  250, 5, 2},
    '{-800,  900,   10, 2, 0}, '{ 600, -700,  300, 1, 1}, '{   0,    0, 1200, 0, 2},
    '{-300, -300, -300, 5, 0}, '{ 700,  -50, -650, 3, 1}, '{ 110,  990, -440, 4, 2},
    '{-1000, 500,  500, 0, 0}, '{ 420, -420,  840, 2, 1}, '{  90, -900,   60, 1, 2},
    '{ 330,  660, -990, 5, 0}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, win_long = 1'b0, live_ready = 1'b1;
  logic [NCH*SW-1:0] in_data = '0;
  logic [ANGW-1:0] dir_sel = '0, pol_sel = '0;
  logic [CHW-1:0] mic_sel = '0;
  logic in_ready, live_valid, pol_valid;
  logic signed [SUMW-1:0] live_beam;
  logic [SW-1:0] live_mic;
  logic [ACCW-1:0] pol_energy;
  logic [ANGW-1:0] dom_angle;

  int errors = 0, checks = 0;
  int hx [NCH][256];
  int n_in = 0, win_pos = 0, mlen = WS;
  longint macc [NANG], mres [NANG];
  bit mvalid = 0;
  int mdom = 0;

  always #2 clk = ~clk;

  beam_scan_top #(.NUM_CH(NCH), .SAMPLE_W(SW), .NUM_ANG(NANG), .DLY_DEPTH(DEPTH),
                  .WIN_SHORT(WS), .WIN_LONG(WL), .DLY_TABLE(pack_tbl())) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .win_long(win_long), .dir_sel(dir_sel), .mic_sel(mic_sel), .live_valid(live_valid),
    .live_ready(live_ready), .live_beam(live_beam), .live_mic(live_mic), .pol_sel(pol_sel),
    .pol_energy(pol_energy), .pol_valid(pol_valid), .dom_angle(dom_angle));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic model_reset();
    n_in = 0; win_pos = 0; mvalid = 0; mdom = 0; mlen = WS;
    for (int a = 0; a < NANG; a++) begin macc[a] = 0; mres[a] = 0; end
  endtask

  task automatic check_polar();
    check(pol_valid == 1'b1, "R8 pol_valid after window", pol_valid, 1);
    check(dom_angle == ANGW'(mdom), "R7 dominant angle", dom_angle, mdom);
    for (int a = 0; a < NANG; a++) begin
      @(negedge clk);
      pol_sel = ANGW'(a);
      #1;
      check(pol_energy == ACCW'(mres[a] / mlen), "R6 R5 mean-square level", pol_energy, mres[a] / mlen);
    end
  endtask

  // Sends one beat, updates the model and checks the live stream and polar results.
  task automatic send(input int s0, input int s1, input int s2, input int dir, input int mic, input bit stall);
    int k, sv[NCH];
    longint beams[NANG], best;
    bit active, wend, seen;
    sv[0] = s0; sv[1] = s1; sv[2] = s2;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data = {SW'(s2), SW'(s1), SW'(s0)};
    dir_sel = ANGW'(dir); mic_sel = CHW'(mic);
    live_ready = !stall;
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    for (int c = 0; c < NCH; c++) hx[c][n_in] = sv[c];
    n_in++;
    k = n_in;
    active = (k >= DEPTH);
    wend = 0;
    if (active) begin
      for (int a = 0; a < NANG; a++) begin
        beams[a] = 0;
        for (int c = 0; c < NCH; c++) beams[a] += hx[c][k-1-DLY[a][c]];
      end
      if (win_pos == 0) mlen = win_long ? WL : WS;
      for (int a = 0; a < NANG; a++) macc[a] += beams[a] * beams[a];
      win_pos++;
      if (win_pos == mlen) begin
        wend = 1; win_pos = 0; mvalid = 1; best = -1;
        for (int a = 0; a < NANG; a++) begin
          mres[a] = macc[a]; macc[a] = 0;
          if (mres[a] > best) begin best = mres[a]; mdom = a; end
        end
      end
    end
    seen = 0;
    for (int i = 0; i < NANG + 8; i++) begin
      @(negedge clk);
      if (live_valid) begin seen = 1; break; end
    end
    if (!active) begin
      check(!seen, "R4 no live beat while filling", seen, 0);
      check(pol_valid == 1'b0, "R4 R8 pol_valid low while filling", pol_valid, 0);
    end else begin
      check(seen, "R3 live beat per processed beat", seen, 1);
      check($signed(live_beam) == beams[dir], "R2 R3 steered beam value", $signed(live_beam), beams[dir]);
      check($signed(live_mic) == longint'(sv[mic]), "R3 selected microphone", $signed(live_mic), sv[mic]);
      if (stall) begin
        for (int i = 0; i < 5; i++) begin
          @(negedge clk);
          check(live_valid && !in_ready, "R1 stalled beat held, input closed", {live_valid, in_ready}, 2);
          check($signed(live_beam) == beams[dir], "R1 stalled data stable", $signed(live_beam), beams[dir]);
        end
        live_ready = 1'b1;
        @(negedge clk);
        check(!live_valid, "R1 beat leaves once taken", live_valid, 0);
      end
      if (wend) check_polar();
      else if (!mvalid) check(pol_valid == 1'b0, "R8 pol_valid low before first window", pol_valid, 0);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R9 in_ready in reset", in_ready, 1);
    check(live_valid == 1'b0, "R9 live_valid in reset", live_valid, 0);
    check(pol_valid == 1'b0, "R9 pol_valid in reset", pol_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && !pol_valid, "R9 idle after reset", in_ready, 1);

    // Table walk: fill, then three short windows.
    win_long = 1'b0;
    for (int i = 0; i < 20; i++)
      send(VEC[i%16][0], VEC[i%16][1], VEC[i%16][2], VEC[i%16][3], VEC[i%16][4], 1'b0);

    // Long mode asked mid-window: current short window finishes first, next is long.
    win_long = 1'b1;
    for (int i = 0; i < 3; i++)
      send(VEC[(i+5)%16][0], VEC[(i+5)%16][1], VEC[(i+5)%16][2], VEC[(i+5)%16][3], VEC[(i+5)%16][4], i == 1);
    check(mlen == WS, "R5 window in progress keeps short length", mlen, WS);
    for (int i = 0; i < 3; i++)
      send(VEC[(i+9)%16][0], VEC[(i+9)%16][1], VEC[(i+9)%16][2], VEC[(i+9)%16][3], VEC[(i+9)%16][4], 1'b0);
    win_long = 1'b0; // ignored inside the running long window
    for (int i = 0; i < 5; i++)
      send(VEC[(i+3)%16][0], VEC[(i+3)%16][1], VEC[(i+3)%16][2], VEC[(i+3)%16][3], VEC[(i+3)%16][4], 1'b0);
    check(mlen == WL, "R5 long window kept despite mid-window change", mlen, WL);

    // Uniform signal: every angle ties, lowest index must win.
    for (int i = 0; i < 12; i++) send(500, 500, 500, i % NANG, i % NCH, 1'b0);
    check(dom_angle == '0, "R7 tie resolves to lowest angle", dom_angle, 0);

    // Reset in mid-run.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(pol_valid == 1'b0 && !live_valid && in_ready, "R9 R8 reset clears results", pol_valid, 0);
    rst_n = 1'b1;
    model_reset();
    for (int i = 0; i < DEPTH + 1; i++)
      send(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], 1'b0);
    finish_run();
  end
endmodule